// File: doc/BRIEF.md
# Handshake Channel Watchdog Monitor

This block sits beside a single VALID/READY channel and only listens. Every clock it samples the valid strobe, the ready strobe, the payload bus, and a `pending_work` hint from the source that says data is queued. It looks for four kinds of misbehaviour. The first is a beat withdrawn while it was still waiting. The second is a payload that changes under a waiting beat. The third is a beat that is left unaccepted for too long. The fourth is a channel where both strobes sit idle while the source claims to have work. Each problem sets its own sticky flag, and a combined flag is raised when any of them is set.

The block also keeps a record of which problem showed up first and the cycle index at which it did. It counts transfers, stalled cycles and elapsed cycles since reset. Dividing transfers by the cycles in which the valid strobe was high gives the channel's utilization. A value that stays close to one half points to a register stage that inserts bubbles. The monitor never drives the channel and knows nothing about the meaning of the payload.

Top module: `hs_watch`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, every flag, counter, `first_code` and `first_cycle` reads zero.
- R2: Suppose one cycle has valid high and ready low, and the next cycle has valid low. Then `err_drop` is set after the clock edge that ends that second cycle.
- R3: Suppose one cycle has valid high and ready low, and the next cycle still has valid high but a different `ch_data`. Then `err_mutate` is set after the edge that ends that second cycle. A payload held steady sets nothing.
- R4: A run of consecutive cycles with valid high and ready low sets `err_stuck` only on its (STALL_LIMIT+1)th cycle. A run of STALL_LIMIT cycles or fewer is legal backpressure and sets nothing.
- R5: The stall run starts again from zero on every transfer (valid and ready both high) and on every cycle with valid low.
- R6: A run of consecutive cycles in which valid and ready are both low while `pending_work` is high sets `err_deadlock` on its (IDLE_LIMIT+1)th cycle. Idle cycles with `pending_work` low set nothing and break the run.
- R7: `xfer_count` counts cycles with valid and ready both high. `stall_count` counts cycles with valid high and ready low. `cycle_count` counts cycles since reset.
- R8: Every error flag stays set until reset. `err_any` is high exactly when at least one error flag is set.
- R9: `first_code` records the first check that fired: 0 none, 1 dropped beat, 2 payload change, 3 stuck beat, 4 deadlock. When two checks fire in the same cycle, the lower code wins. `first_cycle` holds the `cycle_count` value of the cycle in which that check fired. Both values then stay fixed until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_valid | input | 1 | Observed valid strobe |
| ch_ready | input | 1 | Observed ready strobe |
| ch_data | input | DW | Observed payload |
| pending_work | input | 1 | Source reports queued data |
| err_drop | output | 1 | Sticky flag: beat withdrawn before transfer |
| err_mutate | output | 1 | Sticky flag: payload changed while waiting |
| err_stuck | output | 1 | Sticky flag: beat unaccepted beyond limit |
| err_deadlock | output | 1 | Sticky flag: idle channel with pending work |
| err_any | output | 1 | OR of all error flags |
| first_code | output | 3 | Code of the first check that fired |
| first_cycle | output | CW | Cycle index of the first error |
| xfer_count | output | CW | Transfers since reset |
| stall_count | output | CW | Stalled cycles since reset |
| cycle_count | output | CW | Cycles since reset |

## Verification
The first stimulus is a well-behaved source that holds each beat, facing random backpressure. It separates legal stalls from errors, so only the stuck-beat check may fire, and only when a stall runs past the limit. The second stimulus drives fully random strobes, payloads and pending hints, which makes every check fire in many orders. This tests the first-error priority and the stickiness of the flags against the bench model. Directed sequences cover the exact boundaries: a stall of exactly the limit against one cycle longer, a stall broken by a transfer, idle cycles with and without pending work, and a payload change that lands on the same cycle as a stall timeout.

// File: rtl/hs_watch_pkg.sv
package hs_watch_pkg;

  // Error codes; lower value wins when several fire together
  typedef enum logic [2:0] {
    HS_NONE     = 3'd0,
    HS_DROP     = 3'd1,
    HS_MUTATE   = 3'd2,
    HS_STUCK    = 3'd3,
    HS_DEADLOCK = 3'd4
  } hs_code_e;

  typedef struct packed {
    logic drop;
    logic mutate;
    logic stuck;
    logic deadlock;
  } hs_evt_t;

  localparam int HS_NUM_TALLY = 3;

endpackage

// File: rtl/hs_beat_track.sv
module hs_beat_track #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic          ready,
  input  logic [DW-1:0] data,
  output logic          drop_evt,
  output logic          mutate_evt
);

  logic          wait_q, wait_d;
  logic [DW-1:0] held_q, held_d;
  logic          held_en;

  // A beat is waiting when offered but not taken
  always_comb begin
    wait_d  = valid & ~ready;
    held_en = valid & ~ready;
    held_d  = data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
    end else begin
      wait_q <= wait_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (held_en) begin
      held_q <= held_d;
    end
  end

  always_comb begin
    drop_evt   = wait_q & ~valid;
    mutate_evt = wait_q & valid & (data != held_q);
  end

endmodule

// File: rtl/hs_run_timer.sv
module hs_run_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic trip
);

  localparam int W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  // Counts prior consecutive run cycles, saturating at LIMIT
  always_comb begin
    cnt_en = run | (cnt_q != '0);
    if (!run) begin
      cnt_d = '0;
    end else if (cnt_q == LIM) begin
      cnt_d = cnt_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign trip = run & (cnt_q == LIM);

endmodule

// File: rtl/hs_tally.sv
module hs_tally
  import hs_watch_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [HS_NUM_TALLY-1:0]          inc,
  output logic [HS_NUM_TALLY-1:0][CW-1:0] count
);

  for (genvar i = 0; i < HS_NUM_TALLY; i++) begin : g_cnt
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
      cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (inc[i]) begin
        cnt_q <= cnt_d;
      end
    end

    assign count[i] = cnt_q;
  end

endmodule

// File: rtl/hs_first_err.sv
module hs_first_err
  import hs_watch_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hs_evt_t       evt,
  input  logic [CW-1:0] now,
  output logic [2:0]    code,
  output logic [CW-1:0] at_cycle
);

  hs_code_e      code_q, code_d, pick;
  logic [CW-1:0] at_q, at_d;
  logic          cap_en;

  // Fixed priority: lower code first
  always_comb begin
    pick = HS_NONE;
    if (evt.drop) begin
      pick = HS_DROP;
    end else if (evt.mutate) begin
      pick = HS_MUTATE;
    end else if (evt.stuck) begin
      pick = HS_STUCK;
    end else if (evt.deadlock) begin
      pick = HS_DEADLOCK;
    end
  end

  always_comb begin
    cap_en = (code_q == HS_NONE) && (pick != HS_NONE);
    code_d = pick;
    at_d   = now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= HS_NONE;
      at_q   <= '0;
    end else if (cap_en) begin
      code_q <= code_d;
      at_q   <= at_d;
    end
  end

  assign code     = code_q;
  assign at_cycle = at_q;

endmodule

// File: rtl/hs_watch.sv
module hs_watch
  import hs_watch_pkg::*;
#(
  parameter int DW          = 32,
  parameter int CW          = 32,
  parameter int STALL_LIMIT = 16,
  parameter int IDLE_LIMIT  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ch_valid,
  input  logic          ch_ready,
  input  logic [DW-1:0] ch_data,
  input  logic          pending_work,
  output logic          err_drop,
  output logic          err_mutate,
  output logic          err_stuck,
  output logic          err_deadlock,
  output logic          err_any,
  output logic [2:0]    first_code,
  output logic [CW-1:0] first_cycle,
  output logic [CW-1:0] xfer_count,
  output logic [CW-1:0] stall_count,
  output logic [CW-1:0] cycle_count
);

  localparam int T_XFER  = 0;
  localparam int T_STALL = 1;
  localparam int T_CYCLE = 2;

  hs_evt_t evt;
  hs_evt_t flags_q, flags_d;
  logic    stall_run, idle_run;
  logic    flags_en;
  logic [HS_NUM_TALLY-1:0]          tally_inc;
  logic [HS_NUM_TALLY-1:0][CW-1:0] tally;

  always_comb begin
    stall_run = ch_valid & ~ch_ready;
    idle_run  = ~ch_valid & ~ch_ready & pending_work;
  end

  hs_beat_track #(.DW(DW)) u_beat (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (ch_valid),
    .ready      (ch_ready),
    .data       (ch_data),
    .drop_evt   (evt.drop),
    .mutate_evt (evt.mutate)
  );

  hs_run_timer #(.LIMIT(STALL_LIMIT)) u_stall_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (stall_run),
    .trip  (evt.stuck)
  );

  hs_run_timer #(.LIMIT(IDLE_LIMIT)) u_idle_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (idle_run),
    .trip  (evt.deadlock)
  );

  always_comb begin
    tally_inc          = '0;
    tally_inc[T_XFER]  = ch_valid & ch_ready;
    tally_inc[T_STALL] = stall_run;
    tally_inc[T_CYCLE] = 1'b1;
  end

  hs_tally #(.CW(CW)) u_tally (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (tally_inc),
    .count (tally)
  );

  hs_first_err #(.CW(CW)) u_first (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .now      (tally[T_CYCLE]),
    .code     (first_code),
    .at_cycle (first_cycle)
  );

  // Sticky flags
  always_comb begin
    flags_en = |evt;
    flags_d  = flags_q | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  assign err_drop     = flags_q.drop;
  assign err_mutate   = flags_q.mutate;
  assign err_stuck    = flags_q.stuck;
  assign err_deadlock = flags_q.deadlock;
  assign err_any      = |flags_q;
  assign xfer_count   = tally[T_XFER];
  assign stall_count  = tally[T_STALL];
  assign cycle_count  = tally[T_CYCLE];

endmodule

// File: rtl/hs_watch_chk.sv
module hs_watch_chk #(
  parameter int DW = 32,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ch_valid,
  input logic          ch_ready,
  input logic [DW-1:0] ch_data,
  input logic          pending_work,
  input logic          err_drop,
  input logic          err_stuck,
  input logic          err_deadlock,
  input logic          err_any,
  input logic [2:0]    first_code,
  input logic [CW-1:0] first_cycle,
  input logic [CW-1:0] xfer_count
);

  // R2
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_valid && $past(ch_valid && !ch_ready)) |=> err_drop);

  // R4
  stuck_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_stuck) |-> $past(ch_valid && !ch_ready));

  // R6
  deadlock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_deadlock) |-> $past(!ch_valid && !ch_ready && pending_work));

  // R7
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ch_valid && ch_ready) |-> $stable(xfer_count));

  // R8
  any_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |=> err_any);

  // R9
  code_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |-> (first_code != 3'd0));

  // R9
  code_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_any |-> (first_code == 3'd0));

  // R9
  first_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_code != 3'd0) |=> ($stable(first_code) && $stable(first_cycle)));

endmodule

bind hs_watch hs_watch_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ch_valid     (ch_valid),
  .ch_ready     (ch_ready),
  .ch_data      (ch_data),
  .pending_work (pending_work),
  .err_drop     (err_drop),
  .err_stuck    (err_stuck),
  .err_deadlock (err_deadlock),
  .err_any      (err_any),
  .first_code   (first_code),
  .first_cycle  (first_cycle),
  .xfer_count   (xfer_count)
);

// File: tb/hs_watch_test.sv
module hs_watch_test;

  localparam int DW = 8;
  localparam int CW = 16;
  localparam int SL = 8;
  localparam int IL = 6;

  logic          clk;
  logic          rst_n;
  logic          ch_valid, ch_ready, pending_work;
  logic [DW-1:0] ch_data;
  logic          err_drop, err_mutate, err_stuck, err_deadlock, err_any;
  logic [2:0]    first_code;
  logic [CW-1:0] first_cycle, xfer_count, stall_count, cycle_count;

  int n_checks;
  int n_fail;

  // Reference model state
  logic          m_pp;
  logic [DW-1:0] m_pd;
  int m_st, m_id, m_x, m_s, m_c, m_code, m_fc;
  logic m_fd, m_fm, m_fs, m_fl;

  hs_watch #(.DW(DW), .CW(CW), .STALL_LIMIT(SL), .IDLE_LIMIT(IL)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ch_valid     (ch_valid),
    .ch_ready     (ch_ready),
    .ch_data      (ch_data),
    .pending_work (pending_work),
    .err_drop     (err_drop),
    .err_mutate   (err_mutate),
    .err_stuck    (err_stuck),
    .err_deadlock (err_deadlock),
    .err_any      (err_any),
    .first_code   (first_code),
    .first_cycle  (first_cycle),
    .xfer_count   (xfer_count),
    .stall_count  (stall_count),
    .cycle_count  (cycle_count)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_pp = 1'b0; m_pd = '0; m_st = 0; m_id = 0;
    m_x = 0; m_s = 0; m_c = 0; m_code = 0; m_fc = 0;
    m_fd = 1'b0; m_fm = 1'b0; m_fs = 1'b0; m_fl = 1'b0;
  endtask

  task automatic compare_all();
    chk("R2 err_drop", int'(err_drop), int'(m_fd));
    chk("R3 err_mutate", int'(err_mutate), int'(m_fm));
    chk("R4 err_stuck", int'(err_stuck), int'(m_fs));
    chk("R6 err_deadlock", int'(err_deadlock), int'(m_fl));
    chk("R8 err_any", int'(err_any), int'(m_fd | m_fm | m_fs | m_fl));
    chk("R9 first_code", int'(first_code), m_code);
    chk("R9 first_cycle", int'(first_cycle), m_fc);
    chk("R7 xfer_count", int'(xfer_count), m_x);
    chk("R7 stall_count", int'(stall_count), m_s);
    chk("R7 cycle_count", int'(cycle_count), m_c);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ch_valid = 1'b0; ch_ready = 1'b0;
    ch_data = '0; pending_work = 1'b0;
    model_clear();
    repeat (2) @(posedge clk);
    #1;
    compare_all();
    rst_n = 1'b1;
  endtask

  // Drive one cycle, advance one edge, update the model, compare
  task automatic step(input logic v, input logic r, input logic [DW-1:0] d, input logic p);
    logic ed, em, es, el;
    ch_valid = v; ch_ready = r; ch_data = d; pending_work = p;
    @(posedge clk);
    ed = m_pp && !v;
    em = m_pp && v && (d != m_pd);
    es = v && !r && (m_st == SL);
    el = !v && !r && p && (m_id == IL);
    if (m_code == 0) begin
      if (ed) begin m_code = 1; m_fc = m_c; end
      else if (em) begin m_code = 2; m_fc = m_c; end
      else if (es) begin m_code = 3; m_fc = m_c; end
      else if (el) begin m_code = 4; m_fc = m_c; end
    end
    m_fd |= ed; m_fm |= em; m_fs |= es; m_fl |= el;
    if (v && r) m_x++;
    if (v && !r) m_s++;
    m_c++;
    if (v && !r) m_st = (m_st == SL) ? SL : m_st + 1;
    else m_st = 0;
    if (!v && !r && p) m_id = (m_id == IL) ? IL : m_id + 1;
    else m_id = 0;
    m_pp = v && !r;
    if (v && !r) m_pd = d;
    #1;
    compare_all();
  endtask

  initial begin : watchdog
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic have;
    logic [DW-1:0] dat;
    void'($urandom(32'h1ee7));
    n_checks = 0;
    n_fail = 0;

    // R1 reset state
    do_reset();
    chk("R1 err_any", int'(err_any), 0);
    chk("R1 cycle_count", int'(cycle_count), 0);
    step(1'b0, 1'b0, '0, 1'b0);
    chk("R1 first_code", int'(first_code), 0);

    // R2 dropped beat
    do_reset();
    step(1'b1, 1'b0, 8'hA5, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b0);
    chk("R2 drop set", int'(err_drop), 1);
    chk("R9 drop code", int'(first_code), 1);
    chk("R9 drop cycle", int'(first_cycle), 1);
    step(1'b0, 1'b0, 8'h00, 1'b0);
    chk("R8 drop sticky", int'(err_drop), 1);
    chk("R8 any", int'(err_any), 1);

    // R3 mutated payload, then legal hold
    do_reset();
    step(1'b1, 1'b0, 8'h11, 1'b0);
    step(1'b1, 1'b1, 8'h22, 1'b0);
    chk("R3 mutate set", int'(err_mutate), 1);
    chk("R9 mutate code", int'(first_code), 2);
    do_reset();
    step(1'b1, 1'b0, 8'h33, 1'b0);
    step(1'b1, 1'b1, 8'h33, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b0);
    chk("R3 held payload", int'(err_mutate), 0);
    chk("R2 no drop after transfer", int'(err_drop), 0);
    chk("R7 xfer", int'(xfer_count), 1);
    chk("R7 stall", int'(stall_count), 1);
    chk("R7 cycles", int'(cycle_count), 3);

    // R4 stall limit boundary
    do_reset();
    repeat (SL) step(1'b1, 1'b0, 8'h07, 1'b0);
    chk("R4 at limit legal", int'(err_stuck), 0);
    step(1'b1, 1'b0, 8'h07, 1'b0);
    chk("R4 past limit", int'(err_stuck), 1);
    chk("R9 stuck code", int'(first_code), 3);
    chk("R9 stuck cycle", int'(first_cycle), SL);

    // R5 transfer restarts the stall run
    do_reset();
    repeat (SL) step(1'b1, 1'b0, 8'h09, 1'b0);
    step(1'b1, 1'b1, 8'h09, 1'b0);
    repeat (SL) step(1'b1, 1'b0, 8'h09, 1'b0);
    chk("R5 restart on transfer", int'(err_stuck), 0);

    // R6 deadlock with and without pending work
    do_reset();
    repeat (IL) step(1'b0, 1'b0, 8'h00, 1'b1);
    chk("R6 at limit", int'(err_deadlock), 0);
    step(1'b0, 1'b0, 8'h00, 1'b1);
    chk("R6 past limit", int'(err_deadlock), 1);
    chk("R9 deadlock code", int'(first_code), 4);
    do_reset();
    repeat (3 * IL) step(1'b0, 1'b0, 8'h00, 1'b0);
    chk("R6 no pending", int'(err_deadlock), 0);

    // R9 same-cycle priority: payload change on the stall timeout cycle
    do_reset();
    repeat (SL) step(1'b1, 1'b0, 8'h01, 1'b0);
    step(1'b1, 1'b0, 8'h02, 1'b0);
    chk("R9 both flags mutate", int'(err_mutate), 1);
    chk("R9 both flags stuck", int'(err_stuck), 1);
    chk("R9 priority code", int'(first_code), 2);

    // Well-behaved source under random backpressure
    do_reset();
    have = 1'b0;
    dat = '0;
    for (int i = 0; i < 800; i++) begin
      logic r;
      if (!have && ($urandom % 2 == 0)) begin
        have = 1'b1;
        dat = DW'($urandom);
      end
      r = ($urandom % 3) != 0;
      step(have, r, dat, 1'($urandom));
      if (have && r) have = 1'b0;
    end
    chk("R2 legal source no drop", int'(err_drop), 0);
    chk("R3 legal source no mutate", int'(err_mutate), 0);

    // Chaotic strobes with periodic resets
    for (int blk = 0; blk < 8; blk++) begin
      do_reset();
      for (int i = 0; i < 120; i++) begin
        logic v, r, p;
        v = ($urandom % 4) != 0;
        r = ($urandom % 5) == 0;
        p = 1'($urandom);
        if (blk % 2 == 1) begin
          v = ($urandom % 6) == 0;
          r = 1'b0;
        end
        step(v, r, DW'($urandom % 3), p);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule